// File: doc/BRIEF.md
# Two-Step Hybrid Pulse-Width Modulator

This block drives the high-side switch of a digitally controlled buck converter. Each switching period produces one pulse, and a 6-bit duty word sets its width. Part of the resolution comes from counting clocks and part from a delay line. The upper three bits of the word are compared against a 3-bit period counter. That comparison picks the clock slot in which the pulse must end. The lower three bits pick one of eight delayed clock phases, and that phase places the falling edge inside the chosen slot. The period is eight clocks long, so a 16 MHz system clock gives a 2 MHz switching rate with 1/64-period resolution. A counter alone would need a clock eight times faster to reach the same resolution.

The delay line and its calibration loop sit outside this block. The eight phases arrive on an input vector. Tap i is low at the start of every clock slot, rises i/8 of a slot after the clock edge, and stays high until the slot ends. The block registers the duty word only when the counter wraps. A strobe marks the first slot of every period.

Top module: `hybrid_dpwm`

## Requirements
- R1: While `rst` is high, `pwm_out` is 0 and `period_strobe` is 1, because the slot counter is held at 0. The captured duty value is cleared, so the first period after reset carries no pulse. A reset that is present at a wrap edge overrides the pulse set at that edge.
- R2: The slot counter steps 0,1,...,7,0 on each clock. `period_strobe` is high during slot 0 only, which is one clock out of every eight.
- R3: `duty_word` is captured only at the edge where the counter goes from 7 to 0. Changes to `duty_word` at any other time leave the current period unchanged. The value present at the wrap edge governs the whole of the next period.
- R4: When the captured value is nonzero, `pwm_out` rises at the start of slot 0 and stays high through every slot whose index is below the coarse field (bits [5:3]).
- R5: In the slot whose index equals bits [5:3], `pwm_out` falls when `phase_taps[bits 2:0]` rises. The total high time is therefore the duty word measured in eighths of a clock slot.
- R6: After its falling edge, `pwm_out` stays low for the rest of the period, giving one contiguous pulse per period.
- R7: A captured duty value of 0 gives no pulse in that period. The maximum value of 63 leaves the output low only for the final eighth of slot 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period spans eight of its cycles |
| rst | input | 1 | Synchronous reset, active high |
| duty_word | input | 6 | Duty request: [5:3] selects the end slot, [2:0] selects the end tap |
| phase_taps | input | 8 | Delayed phases; tap i rises i/8 of a slot after each clock edge |
| pwm_out | output | 1 | High-side duty pulse |
| period_strobe | output | 1 | High during the first slot of each period |

## Verification
A duty word that is present at a wrap edge shows up as pulse width during the following period, never during the period already running. For that reason, each expected width is queued when the word is driven in slot 0, and it is compared one period boundary later. The output is sampled eight times per slot, at fixed offsets placed between tap edges and clock edges. The count of high samples over one period therefore equals the duty word directly. The strobe is checked by counting exactly eight high samples per period. Reset is checked one sample after the reset edge takes effect.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int COARSE_W = 3;
    localparam int FINE_W   = 3;
    localparam int DUTY_W   = COARSE_W + FINE_W;
    localparam int SLOTS    = 1 << COARSE_W;
    localparam int TAPS     = 1 << FINE_W;

    typedef logic [COARSE_W-1:0] slot_t;
    typedef logic [FINE_W-1:0]   tap_t;

    typedef struct packed {
        slot_t coarse;
        tap_t  fine;
    } duty_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SET   = 2'd1,
        ACT_CLEAR = 2'd2,
        ACT_FORCE = 2'd3
    } latch_act_e;

    function automatic duty_t split_duty(input logic [DUTY_W-1:0] word);
        duty_t d;
        d.coarse = word[DUTY_W-1:FINE_W];
        d.fine   = word[FINE_W-1:0];
        return d;
    endfunction

    function automatic logic duty_is_zero(input duty_t d);
        return (d.coarse == '0) && (d.fine == '0);
    endfunction

endpackage

// File: rtl/dpwm_slot_counter.sv
module dpwm_slot_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] slot,
    output logic         wrap,
    output logic         first
);

    logic [W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign slot  = slot_q;
    assign wrap  = &slot_q;
    assign first = (slot_q == '0);

endmodule

// File: rtl/dpwm_duty_reg.sv
module dpwm_duty_reg
    import dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DUTY_W-1:0] word_in,
    output duty_t             held,
    output logic              next_zero
);

    duty_t held_q;
    duty_t incoming;

    assign incoming = split_duty(word_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= incoming;
        end
    end

    assign held      = held_q;
    assign next_zero = duty_is_zero(incoming);

endmodule

// File: rtl/dpwm_tap_mux.sv
module dpwm_tap_mux #(
    parameter int N  = 8,
    parameter int SW = 3
) (
    input  logic [N-1:0]  taps,
    input  logic [SW-1:0] sel,
    output logic          edge_seen
);

    logic [N-1:0] pick;

    for (genvar i = 0; i < N; i++) begin : g_leg
        assign pick[i] = (sel == SW'(i)) & taps[i];
    end

    assign edge_seen = |pick;

endmodule

// File: rtl/dpwm_edge_latch.sv
module dpwm_edge_latch
    import dpwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clear_req,
    input  logic fine_cut,
    output logic pulse
);

    logic       held_q;
    latch_act_e act;

    always_comb begin
        if (rst) begin
            act = ACT_FORCE;
        end else if (set_req) begin
            act = ACT_SET;
        end else if (clear_req) begin
            act = ACT_CLEAR;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        case (act)
            ACT_SET:   held_q <= 1'b1;
            ACT_CLEAR: held_q <= 1'b0;
            ACT_FORCE: held_q <= 1'b0;
            default:   held_q <= held_q;
        endcase
    end

    assign pulse = held_q & ~fine_cut;

endmodule

// File: rtl/hybrid_dpwm.sv
module hybrid_dpwm
    import dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_word,
    input  logic [TAPS-1:0]   phase_taps,
    output logic              pwm_out,
    output logic              period_strobe
);

    slot_t slot;
    logic  wrap;
    logic  first;
    duty_t held;
    logic  next_zero;
    logic  coarse_hit;
    logic  tap_edge;
    logic  fine_cut;
    logic  set_req;

    dpwm_slot_counter #(.W(COARSE_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .slot  (slot),
        .wrap  (wrap),
        .first (first)
    );

    dpwm_duty_reg u_duty (
        .clk       (clk),
        .rst       (rst),
        .load      (wrap),
        .word_in   (duty_word),
        .held      (held),
        .next_zero (next_zero)
    );

    dpwm_tap_mux #(.N(TAPS), .SW(FINE_W)) u_mux (
        .taps      (phase_taps),
        .sel       (held.fine),
        .edge_seen (tap_edge)
    );

    assign coarse_hit = (slot == held.coarse);
    assign fine_cut   = coarse_hit & tap_edge;
    assign set_req    = wrap & ~next_zero;

    dpwm_edge_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .set_req   (set_req),
        .clear_req (coarse_hit),
        .fine_cut  (fine_cut),
        .pulse     (pwm_out)
    );

    assign period_strobe = first;

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker
    import dpwm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DUTY_W-1:0] duty_word,
    input logic [TAPS-1:0]   phase_taps,
    input logic              pwm_out,
    input logic              period_strobe
);

    slot_t gap;
    duty_t cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= '0;
            cap <= '0;
        end else begin
            gap <= gap + 1'b1;
            if (gap == slot_t'(SLOTS - 1)) begin
                cap <= split_duty(duty_word);
            end
        end
    end

    // R2: strobe marks slot 0 only
    assert_strobe_phase_R2: assert property (@(negedge clk) disable iff (rst)
        period_strobe == (gap == '0));

    // R7: zero duty leaves the output low
    assert_zero_idle_R7: assert property (@(negedge clk) disable iff (rst)
        duty_is_zero(cap) |-> !pwm_out);

    // R4: high through slots ahead of the coarse slot
    assert_high_before_coarse_R4: assert property (@(negedge clk) disable iff (rst)
        (!duty_is_zero(cap) && gap < cap.coarse) |-> pwm_out);

    // R5: in the coarse slot the selected tap ends the pulse
    assert_fine_edge_R5: assert property (@(negedge clk) disable iff (rst)
        (!duty_is_zero(cap) && gap == cap.coarse) |-> (pwm_out == !phase_taps[cap.fine]));

    // R6: low after the coarse slot
    assert_low_after_R6: assert property (@(negedge clk) disable iff (rst)
        (gap > cap.coarse) |-> !pwm_out);

endmodule

bind hybrid_dpwm dpwm_checker u_dpwm_checker (
    .clk           (clk),
    .rst           (rst),
    .duty_word     (duty_word),
    .phase_taps    (phase_taps),
    .pwm_out       (pwm_out),
    .period_strobe (period_strobe)
);

// File: tb/test_hybrid_dpwm.sv
`timescale 1ns/1ps
module test_hybrid_dpwm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] duty_word = 6'd0;
    logic [7:0] phase_taps = 8'd0;
    logic       pwm_out;
    logic       period_strobe;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit mon_en = 1'b1;
    bit done = 1'b0;
    event period_ev;

    hybrid_dpwm i_hybrid_dpwm (
        .clk           (clk),
        .rst           (rst),
        .duty_word     (duty_word),
        .phase_taps    (phase_taps),
        .pwm_out       (pwm_out),
        .period_strobe (period_strobe)
    );

    always #2 clk = ~clk;

    // delay-line stand-in: taps clear after the edge, tap i rises i/8 slot later
    always @(posedge clk) begin
        #0.125 phase_taps = 8'd0;
        #0.125 phase_taps[0] = 1'b1;
        for (int i = 1; i < 8; i++) begin
            #0.5 phase_taps[i] = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: eight samples per slot, between tap edges
    int  hi_cnt = 0;
    int  strb_cnt = 0;
    bit  seen_low = 0;
    bit  split = 0;
    bit  started = 0;
    always @(posedge clk) begin
        for (int s = 0; s < 8; s++) begin
            #(s == 0 ? 0.375 : 0.5);
            if (rst || !mon_en) begin
                started = 0;
            end else begin
                if (s == 0 && period_strobe) begin
                    if (started) begin
                        if (exp_q.size() > 0) begin
                            int e;
                            e = exp_q.pop_front();
                            check(hi_cnt == e, "R5 pulse width", hi_cnt, e);
                            check(!split, "R6 single contiguous pulse", int'(split), 0);
                        end
                        check(strb_cnt == 8, "R2 strobe one slot per period", strb_cnt, 8);
                    end
                    started = 1;
                    hi_cnt = 0;
                    strb_cnt = 0;
                    seen_low = 0;
                    split = 0;
                    -> period_ev;
                end
                if (started) begin
                    if (pwm_out) begin
                        hi_cnt++;
                        if (seen_low) split = 1;
                    end else begin
                        seen_low = 1;
                    end
                    if (period_strobe) strb_cnt++;
                end
            end
        end
    end

    // driver: word driven in slot 0 applies to the next period
    task automatic drive(input int d);
        @(period_ev);
        duty_word = 6'(d);
        exp_q.push_back(d);
    endtask

    // R3: several mid-period values, only the last one reaches the wrap
    task automatic drive_wiggle(input int a, input int b);
        @(period_ev);
        duty_word = 6'(a);
        repeat (2) @(posedge clk);
        #1 duty_word = 6'(b ^ 6'h15);
        repeat (2) @(posedge clk);
        #1 duty_word = 6'(b);
        exp_q.push_back(b);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(pwm_out == 1'b0, "R1 output low in reset", int'(pwm_out), 0);
        check(period_strobe == 1'b1, "R1 strobe high in reset", int'(period_strobe), 1);
        exp_q.push_back(0); // R1: first period after reset is empty
        @(negedge clk);
        #0.3 rst = 1'b0;

        drive(1);     // R5 shortest pulse
        drive(7);     // R5 fine only
        drive(8);     // R4 whole slot
        drive(9);
        drive(0);     // R7 no pulse
        drive(31);
        drive(32);
        drive(56);    // R4 coarse 7, fine 0
        drive(62);
        drive(63);    // R7 maximum
        drive(5);
        drive(40);
        drive_wiggle(20, 45); // R3
        drive(0);

        while (exp_q.size() > 0) @(period_ev);

        // R1: reset at the wrap edge beats the set
        @(period_ev);
        mon_en = 1'b0;
        duty_word = 6'd63;
        repeat (7) @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1;
        check(pwm_out == 1'b0, "R1 reset overrides set at wrap", int'(pwm_out), 0);
        check(period_strobe == 1'b1, "R1 counter held at zero", int'(period_strobe), 1);
        @(posedge clk);
        #2;
        check(pwm_out == 1'b0, "R1 output stays low in reset", int'(pwm_out), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule